// File: doc/BRIEF.md
# Burst Cycle Control and Address Generator

This block sits at the front of a synchronous burst memory. On every rising clock edge it samples an external word address, two active-low address strobes (one for a cache controller, one for a processor), an active-low advance input, three chip enables and the write controls. From these it decides whether the cycle starts a new access, continues a burst, holds the burst on its current word, or deselects the device. It then hands the storage datapath the current word address, the cycle kind and a byte-lane write mask.

A burst covers four words in an aligned group. The block loads the full address on a start. Afterwards it makes only the two low address bits itself, in one of two orders. Linear order counts upward and wraps. Interleaved order XORs the start offset with a beat count. A static mode input picks the order, and it is not registered.

The processor strobe only works when the first enable is active, and it always starts a read. A burst it starts becomes a write only through write controls given in a later cycle. If the processor strobe is tied inactive, the controller strobe is tied active, advance is tied inactive and the first enable is tied active, the block loads a new address every cycle. In that case it acts as a plain pipelined front end with no bursts.

Top module: `burst_addr_sequencer`

## Requirements
- R1: While reset is asserted, and after it is released with no start, `deselected` is 1, `cyc_kind` is 0 (idle) and `lane_we` is all zero.
- R2: When `ctl_strobe_n` is low and all enables are active (`en_a_n` low, `en_b` high, `en_c_n` low), the next edge loads `ext_addr` as the burst start (beat 0) and clears `deselected`. The cycle is a read or a write according to the write controls (R12).
- R3: When `ctl_strobe_n` is low and `en_a_n` is high, the next edge deselects the device (`deselected`=1, kind idle, no lanes), whatever the processor strobe is.
- R4: When `cpu_strobe_n` is low, `en_a_n` is low and the other enables are active, the next edge loads `ext_addr` and starts a read. All write controls are ignored in that cycle.
- R5: When `cpu_strobe_n` is low and `en_a_n` is high, with `ctl_strobe_n` high, the processor strobe has no effect. No deselect occurs, the burst continues under `adv_n`, and write controls are still ignored (the cycle is a read).
- R6: A start from either strobe while `en_b` is low or `en_c_n` is high deselects the device at the next edge.
- R7: With both strobes high on a selected device, `adv_n` low steps the burst one beat and `adv_n` high keeps the current address. Each such cycle is a read or a write according to the write controls of that cycle.
- R8: With `interleave` low, the two low address bits equal (start offset + beat) mod 4. A start offset of 2 gives 2, 3, 0, 1, and beat 4 returns to the start offset.
- R9: With `interleave` high, the two low address bits equal start offset XOR beat. A start of 1 gives 1, 0, 3, 2, and a start of 2 gives 2, 3, 0, 1. `interleave` is not registered: a change shows on `cur_addr` with no clock edge.
- R10: Address bits above the low two stay at the loaded value for the whole burst. The burst wraps inside its aligned four-word group.
- R11: While the device is deselected and both strobes are high, it stays deselected whatever `adv_n` and the write controls are.
- R12: Kind encoding: 0 idle, 1 read, 2 write. `gwr_n` low enables every byte lane. Otherwise, with `wr_n` low, lane i is enabled when `lane_wr_n[i]` is low. The cycle is a write only when at least one lane is enabled, and a read otherwise.
- R13: With `cpu_strobe_n` tied high, `ctl_strobe_n` tied low, `adv_n` tied high and `en_a_n` tied low, every cycle presents the address sampled at the edge before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_addr | input | ADDR_W | External word address |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| cpu_strobe_n | input | 1 | Processor address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| en_a_n | input | 1 | Enable A, active low; gates the processor strobe |
| en_b | input | 1 | Enable B, active high |
| en_c_n | input | 1 | Enable C, active low |
| gwr_n | input | 1 | Write all lanes, active low |
| wr_n | input | 1 | Lane-write qualifier, active low |
| lane_wr_n | input | NBYTES | Per-lane write select, active low |
| interleave | input | 1 | Static burst order: 0 linear, 1 interleaved |
| cur_addr | output | ADDR_W | Current word address for the datapath |
| cyc_kind | output | 2 | 0 idle, 1 read, 2 write |
| lane_we | output | NBYTES | Byte lanes written this cycle |
| deselected | output | 1 | Device deselected |

## Verification
Every registered result (`cyc_kind`, `lane_we`, `deselected` and the burst state behind `cur_addr`) is due one rising edge after the inputs that caused it. The bench drives inputs 1 ns after an edge and samples all outputs 1 ns after the following edge, where its arithmetic model has moved one step. The one combinational path, from `interleave` to the two low bits of `cur_addr`, is checked 1 ns after the pin changes, with no clock edge in between. The sweeps cover every start offset in both orders across more than one wrap, every enable and strobe combination, and every lane pattern under both write qualifiers.

// File: rtl/bas_pkg.sv
package bas_pkg;

  localparam int BURST_BITS = 2;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_e;

  // Low address bits for a given beat of a burst.
  function automatic logic [BURST_BITS-1:0] burst_low(
    input logic                  interleaved,
    input logic [BURST_BITS-1:0] start,
    input logic [BURST_BITS-1:0] beat
  );
    if (interleaved) burst_low = start ^ beat;
    else             burst_low = start + beat;
  endfunction

  function automatic logic [BURST_BITS-1:0] beat_next(
    input logic [BURST_BITS-1:0] beat
  );
    beat_next = beat + 1'b1;
  endfunction

endpackage

// File: rtl/bas_cycle_decode.sv
module bas_cycle_decode (
  input  logic ctl_strobe_n,
  input  logic cpu_strobe_n,
  input  logic adv_n,
  input  logic en_a_n,
  input  logic en_b,
  input  logic en_c_n,
  input  logic active,
  output logic do_load,
  output logic do_desel,
  output logic do_step,
  output logic do_hold,
  output logic wr_blocked
);
  logic chip_on;
  logic cpu_go;
  logic ctl_go;
  logic strobe;

  always_comb begin
    chip_on    = !en_a_n && en_b && !en_c_n;
    cpu_go     = !cpu_strobe_n && !en_a_n;
    ctl_go     = !ctl_strobe_n;
    strobe     = cpu_go || ctl_go;
    do_load    = strobe && chip_on;
    do_desel   = strobe && !chip_on;
    do_step    = !strobe && active && !adv_n;
    do_hold    = !strobe && active && adv_n;
    wr_blocked = !cpu_strobe_n;
  end
endmodule

// File: rtl/bas_write_decode.sv
module bas_write_decode #(
  parameter int NBYTES = 4
) (
  input  logic              gwr_n,
  input  logic              wr_n,
  input  logic [NBYTES-1:0] lane_wr_n,
  input  logic              blocked,
  output logic [NBYTES-1:0] lanes,
  output logic              is_write
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    assign lanes[i] = !blocked && (!gwr_n || (!wr_n && !lane_wr_n[i]));
  end
  assign is_write = |lanes;
endmodule

// File: rtl/bas_burst_counter.sv
module bas_burst_counter
  import bas_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              desel,
  input  logic              step,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              interleave,
  output logic [ADDR_W-1:0] addr,
  output logic              active
);
  localparam int HI_W = ADDR_W - BURST_BITS;

  logic [ADDR_W-1:0]     base_q;
  logic [BURST_BITS-1:0] beat_q;
  logic                  active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      beat_q   <= '0;
      active_q <= 1'b0;
    end else if (load) begin
      base_q   <= ext_addr;
      beat_q   <= '0;
      active_q <= 1'b1;
    end else if (desel) begin
      active_q <= 1'b0;
    end else if (step) begin
      beat_q   <= beat_next(beat_q);
    end
  end

  assign addr   = {base_q[ADDR_W-1 -: HI_W],
                   burst_low(interleave, base_q[BURST_BITS-1:0], beat_q)};
  assign active = active_q;
endmodule

// File: rtl/burst_addr_sequencer.sv
module burst_addr_sequencer
  import bas_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              ctl_strobe_n,
  input  logic              cpu_strobe_n,
  input  logic              adv_n,
  input  logic              en_a_n,
  input  logic              en_b,
  input  logic              en_c_n,
  input  logic              gwr_n,
  input  logic              wr_n,
  input  logic [NBYTES-1:0] lane_wr_n,
  input  logic              interleave,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [1:0]        cyc_kind,
  output logic [NBYTES-1:0] lane_we,
  output logic              deselected
);
  logic              active;
  logic              do_load;
  logic              do_desel;
  logic              do_step;
  logic              do_hold;
  logic              wr_blocked;
  logic [NBYTES-1:0] lanes;
  logic              is_write;
  logic              cycle_live;
  cyc_kind_e         kind_q;
  logic [NBYTES-1:0] lanes_q;

  bas_cycle_decode u_dec (
    .ctl_strobe_n (ctl_strobe_n),
    .cpu_strobe_n (cpu_strobe_n),
    .adv_n        (adv_n),
    .en_a_n       (en_a_n),
    .en_b         (en_b),
    .en_c_n       (en_c_n),
    .active       (active),
    .do_load      (do_load),
    .do_desel     (do_desel),
    .do_step      (do_step),
    .do_hold      (do_hold),
    .wr_blocked   (wr_blocked)
  );

  bas_write_decode #(.NBYTES(NBYTES)) u_wr (
    .gwr_n     (gwr_n),
    .wr_n      (wr_n),
    .lane_wr_n (lane_wr_n),
    .blocked   (wr_blocked),
    .lanes     (lanes),
    .is_write  (is_write)
  );

  bas_burst_counter #(.ADDR_W(ADDR_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (do_load),
    .desel      (do_desel),
    .step       (do_step),
    .ext_addr   (ext_addr),
    .interleave (interleave),
    .addr       (cur_addr),
    .active     (active)
  );

  assign cycle_live = do_load || do_step || do_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= CYC_IDLE;
      lanes_q <= '0;
    end else if (cycle_live) begin
      kind_q  <= is_write ? CYC_WRITE : CYC_READ;
      lanes_q <= lanes;
    end else begin
      kind_q  <= CYC_IDLE;
      lanes_q <= '0;
    end
  end

  assign cyc_kind   = kind_q;
  assign lane_we    = lanes_q;
  assign deselected = !active;
endmodule

// File: rtl/bas_checker.sv
module bas_checker #(
  parameter int ADDR_W = 16,
  parameter int NBYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              ctl_strobe_n,
  input logic              cpu_strobe_n,
  input logic              adv_n,
  input logic              en_a_n,
  input logic              en_b,
  input logic              en_c_n,
  input logic              interleave,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [1:0]        cyc_kind,
  input logic [NBYTES-1:0] lane_we,
  input logic              deselected
);
  logic both_high;
  assign both_high = ctl_strobe_n && cpu_strobe_n;

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (deselected && cyc_kind == 2'd0 && lane_we == '0));

  p_ctl_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_strobe_n && en_a_n) |=> (deselected && cyc_kind == 2'd0));

  p_cpu_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_strobe_n && !en_a_n && en_b && !en_c_n)
    |=> (!deselected && cyc_kind == 2'd1 && lane_we == '0 &&
         cur_addr == $past(ext_addr)));

  p_enable_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ctl_strobe_n || (!cpu_strobe_n && !en_a_n)) && (!en_b || en_c_n))
    |=> deselected);

  p_hold_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (both_high && adv_n && !deselected)
    |=> (cur_addr == $past(cur_addr) || interleave != $past(interleave)));

  p_linear_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (both_high && !adv_n && !deselected && !interleave)
    |=> (interleave || cur_addr[1:0] == 2'($past(cur_addr[1:0]) + 2'd1)));

  p_upper_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (both_high && !deselected)
    |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

  p_stay_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (both_high && deselected) |=> deselected);
endmodule

bind burst_addr_sequencer bas_checker #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ext_addr     (ext_addr),
  .ctl_strobe_n (ctl_strobe_n),
  .cpu_strobe_n (cpu_strobe_n),
  .adv_n        (adv_n),
  .en_a_n       (en_a_n),
  .en_b         (en_b),
  .en_c_n       (en_c_n),
  .interleave   (interleave),
  .cur_addr     (cur_addr),
  .cyc_kind     (cyc_kind),
  .lane_we      (lane_we),
  .deselected   (deselected)
);

// File: tb/burst_addr_sequencer_tb.sv
module burst_addr_sequencer_tb;
  localparam int AW = 16;
  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          ctl_n = 1'b1, cpu_n = 1'b1, adv_n = 1'b1;
  logic          ea_n = 1'b0, eb = 1'b1, ec_n = 1'b0;
  logic          gw_n = 1'b1, w_n = 1'b1;
  logic [NB-1:0] ln_n = '1;
  logic          ilv = 1'b0;
  logic [AW-1:0] cur_addr;
  logic [1:0]    cyc_kind;
  logic [NB-1:0] lane_we;
  logic          deselected;

  int checks = 0;
  int errors = 0;

  // bench model state
  bit            m_act = 0;
  bit [AW-1:0]   m_base = '0;
  int            m_beat = 0;
  int            m_kind = 0;
  bit [NB-1:0]   m_lanes = '0;

  always #2 clk = ~clk;

  burst_addr_sequencer #(.ADDR_W(AW), .NBYTES(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
    .ctl_strobe_n(ctl_n), .cpu_strobe_n(cpu_n), .adv_n(adv_n),
    .en_a_n(ea_n), .en_b(eb), .en_c_n(ec_n),
    .gwr_n(gw_n), .wr_n(w_n), .lane_wr_n(ln_n), .interleave(ilv),
    .cur_addr(cur_addr), .cyc_kind(cyc_kind), .lane_we(lane_we),
    .deselected(deselected)
  );

  function automatic bit [AW-1:0] exp_addr();
    int off;
    off = m_base[1:0];
    if (ilv) begin
      // bitwise XOR written per bit
      exp_addr = {m_base[AW-1:2], off[1] ^ ((m_beat / 2) % 2 == 1),
                  off[0] ^ (m_beat % 2 == 1)};
    end else begin
      exp_addr = {m_base[AW-1:2], 2'((off + m_beat) % 4)};
    end
  endfunction

  task automatic compare(input string req);
    bit [AW-1:0] ea;
    bit ok;
    checks++;
    ea = m_act ? exp_addr() : cur_addr;
    ok = (deselected == !m_act) && (int'(cyc_kind) == m_kind) &&
         (lane_we == m_lanes) && (cur_addr == ea);
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual desel=%0b kind=%0d lanes=%b addr=%h expected desel=%0b kind=%0d lanes=%b addr=%h",
               req, deselected, cyc_kind, lane_we, cur_addr, !m_act, m_kind, m_lanes, ea);
    end
  endtask

  // One clock: model update from pre-edge inputs, then check 1 ns after edge.
  task automatic cyc(input string req);
    bit start, chip;
    bit [NB-1:0] l;
    start = !ctl_n || (!cpu_n && !ea_n);
    chip  = !ea_n && eb && !ec_n;
    if (!cpu_n) l = '0;
    else if (!gw_n) l = '1;
    else if (!w_n) l = ~ln_n;
    else l = '0;
    if (start && chip) begin
      m_act = 1; m_base = ext_addr; m_beat = 0;
      m_lanes = l; m_kind = (l != 0) ? 2 : 1;
    end else if (start) begin
      m_act = 0; m_lanes = '0; m_kind = 0;
    end else if (m_act) begin
      if (!adv_n) m_beat = (m_beat + 1) % 4;
      m_lanes = l; m_kind = (l != 0) ? 2 : 1;
    end else begin
      m_lanes = '0; m_kind = 0;
    end
    @(posedge clk);
    #1;
    compare(req);
  endtask

  task automatic idle_inputs();
    ctl_n = 1; cpu_n = 1; adv_n = 1; ea_n = 0; eb = 1; ec_n = 0;
    gw_n = 1; w_n = 1; ln_n = '1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    compare("R1 in reset");
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1;
    compare("R1 after release");
    cyc("R1 idle cycle");

    // R2: controller start, read then global write
    ext_addr = 16'h1232; ctl_n = 0;
    cyc("R2 ctl read start");
    ext_addr = 16'h4A41; gw_n = 0;
    cyc("R2 ctl write start");
    idle_inputs();

    // R8 R9 R10 R7: every start offset in both orders, with suspends
    for (int o = 0; o < 2; o++) begin
      ilv = o[0];
      for (int s = 0; s < 4; s++) begin
        idle_inputs();
        ext_addr = 16'hBEE0 | 16'(s) | 16'(o << 8);
        ctl_n = 0;
        cyc(o ? "R9 start" : "R8 start");
        ctl_n = 1; ext_addr = 16'h0000;
        for (int b = 0; b < 6; b++) begin
          adv_n = 0;
          cyc(o ? "R9 R10 interleaved step" : "R8 R10 linear step");
          if (b == 2) begin
            adv_n = 1; w_n = 0; ln_n = 4'b1010;
            cyc("R7 suspend holds address, write");
            w_n = 1; ln_n = '1;
          end
        end
      end
    end

    // R9: order pin is not registered
    ilv = 0; idle_inputs();
    ext_addr = 16'h0301; ctl_n = 0; cyc("R9 start for pin test");
    ctl_n = 1; adv_n = 0; cyc("R9 step to beat 1");
    adv_n = 1;
    ilv = 1; #1; compare("R9 interleave pin without clock");
    ilv = 0; #1; compare("R9 linear pin without clock");
    @(posedge clk); #1;

    // R4: processor start ignores writes
    idle_inputs();
    ext_addr = 16'h7776; cpu_n = 0; gw_n = 0; w_n = 0; ln_n = '0;
    cyc("R4 cpu start is read");
    cpu_n = 1; gw_n = 1; w_n = 1; ln_n = '1;
    // R5: processor strobe with enable A high is ignored
    cpu_n = 0; ea_n = 1; adv_n = 0; gw_n = 0;
    cyc("R5 cpu blocked, burst steps as read");
    adv_n = 1;
    cyc("R5 cpu blocked, burst holds");
    idle_inputs();
    gw_n = 0; cyc("R7 continue as write");
    gw_n = 1; cyc("R7 continue as read");

    // R3: controller strobe with enable A high deselects
    ctl_n = 0; ea_n = 1; cpu_n = 0;
    cyc("R3 ctl with enable A high");
    idle_inputs();

    // R11: stays deselected
    adv_n = 0; gw_n = 0; cyc("R11 idle with advance low");
    adv_n = 1; cyc("R11 idle with advance high");
    idle_inputs();

    // R6: every enable and strobe combination
    for (int k = 0; k < 32; k++) begin
      idle_inputs();
      ext_addr = 16'h2000 + 16'(k * 5);
      ctl_n = k[0]; cpu_n = k[1]; ea_n = k[2]; eb = k[3]; ec_n = k[4];
      cyc("R6 R2 R3 R4 R5 enable sweep");
    end
    idle_inputs();
    ext_addr = 16'h5550; ctl_n = 0; cyc("R2 restart");
    ctl_n = 1;

    // R12: lane patterns under each qualifier
    for (int g = 0; g < 2; g++) begin
      for (int w = 0; w < 2; w++) begin
        for (int p = 0; p < 16; p++) begin
          gw_n = g[0]; w_n = w[0]; ln_n = 4'(p);
          adv_n = p[0];
          cyc("R12 write lane sweep");
        end
      end
    end

    // R13: non-burst tie configuration
    idle_inputs();
    ctl_n = 0; cpu_n = 1; adv_n = 1; ea_n = 0;
    for (int i = 0; i < 24; i++) begin
      ext_addr = 16'(i * 1237 + 91);
      gw_n = i[0];
      cyc("R13 fresh address every cycle");
    end
    idle_inputs();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule